// File: doc/BRIEF.md
# Staggered Sixteen-Slice SAR Conversion Sequencer

This block is the digital control for a converter built from sixteen identical successive-approximation slices. The slices share one input clock and take turns sampling the analog input. Each slice repeats a fixed sixteen-clock frame. The frame holds a reference-zero sample, an offset (auto-zero) compare, a gain (auto-calibrate) compare, the input sample, a nine-step binary search and a hand-off of the finished word. The frames of neighbouring slices are one clock apart, so exactly one slice takes the input on every clock, and one finished word can leave the block on every clock.

The block drives a set of phase strobes for each slice. It keeps a 9-bit trial code for each slice's DAC and reads one comparator bit back from each slice. The comparators, DACs, calibration loops and reference ladder sit outside the block. A status output reports when enough clocks have run since reset for the calibration loops to have settled. The transfer stage gives out the word, the index of the slice that produced it and a qualifying pulse.

Top module: `tisar_sequencer`

## Requirements
- R1: While `rst` is high (synchronous, active high), every strobe, `res_valid` and `calibrated` are 0, and every trial code is mid-scale 0x100.
- R2: After reset is released, `zero_stb` has exactly one bit set on every clock. That bit advances by one slice per clock and wraps after slice 15, so each slice's frame repeats every 16 clocks.
- R3: On every clock out of reset, exactly one bit of `samp_stb` is high.
- R4: With n the number of rising edges since reset was released, slice k is in frame step s = (n - k) mod 16. Step 0 raises `zero_stb[k]`, step 1 raises `azero_stb[k]`, step 2 raises `acal_stb[k]`, step 3 raises `samp_stb[k]` and step 15 raises `xfer_stb[k]`.
- R5: In step 4 a slice's trial code is 0x100. In steps 4 to 12 the trial code tests bit 12 - s, most significant bit first. When the comparator bit is 0 at the rising edge ending the step, the tested bit is cleared. In every case, the next lower bit is set for the next step.
- R6: If a slice's comparator reports 1 exactly when its held input is at or above the trial code, the word it hands off equals the held input, for every value from 0 to 511.
- R7: In step 15 of a slice that has sampled since reset, `res_valid` is 1, `res_slice` gives that slice's index and `res_code` gives its trial code. When the slice in step 15 has not sampled since reset, `res_valid` is 0.
- R8: A slice's trial code does not change through steps 13 and 14. It returns to 0x100 at the edge that ends step 15.
- R9: `calibrated` stays 0 until CAL_CYCLES rising edges have passed since reset was released. From then on it is 1.
- R10: A comparator bit is ignored while its slice is outside steps 4 to 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; all state moves on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmp_bit | input | 16 | Comparator decision of each slice |
| zero_stb | output | 16 | Reference-zero sample strobe, one bit per slice |
| azero_stb | output | 16 | Offset compare strobe, one bit per slice |
| acal_stb | output | 16 | Gain compare strobe, one bit per slice |
| samp_stb | output | 16 | Input sample strobe, one bit per slice |
| xfer_stb | output | 16 | Word hand-off strobe, one bit per slice |
| trial_bus | output | 144 | Trial DAC codes; slice k at bits [9k+8:9k] |
| res_valid | output | 1 | Qualifies the handed-off word |
| res_code | output | 9 | Handed-off conversion word |
| res_slice | output | 4 | Index of the slice handing off |
| calibrated | output | 1 | Calibration settle time has elapsed |

## Verification
On every clock, one slice hands off its word while a different slice latches the input and a third slice starts its search at mid-scale. A fault in the schedule therefore shows up as a word paired with the wrong slice, or as a value taken from the wrong cycle. The scoreboard queues each input value at the moment the bench expects the sample. It pops the queue when a word is handed off and compares both the word and the slice index, starting with the extreme codes 0, 511, 256 and 255. In the same cycles, comparator bits for slices outside their search steps are randomized, so any use of those bits corrupts a popped word.

// File: rtl/tisar_pkg.sv
`timescale 1ns/1ps
package tisar_pkg;
  localparam int FRAME_LEN = 16;
  localparam int PH_W      = $clog2(FRAME_LEN);
  localparam int CODE_W    = 9;

  typedef logic [PH_W-1:0]   phase_t;
  typedef logic [CODE_W-1:0] code_t;

  localparam phase_t PH_ZERO      = phase_t'(0);
  localparam phase_t PH_AZERO     = phase_t'(1);
  localparam phase_t PH_ACAL      = phase_t'(2);
  localparam phase_t PH_SAMPLE    = phase_t'(3);
  localparam phase_t PH_SAR_FIRST = phase_t'(4);
  localparam phase_t PH_SAR_LAST  = phase_t'(4 + CODE_W - 1);
  localparam phase_t PH_XFER      = phase_t'(FRAME_LEN - 1);
  localparam code_t  MID_CODE     = code_t'(1) << (CODE_W - 1);

  // Step a slice holds while reset is asserted.
  function automatic phase_t reset_phase(int k);
    return phase_t'((FRAME_LEN - (k % FRAME_LEN)) % FRAME_LEN);
  endfunction

  function automatic logic in_search(phase_t p);
    return (p >= PH_SAR_FIRST) && (p <= PH_SAR_LAST);
  endfunction

  // Bit tested in search step p.
  function automatic int trial_bit(phase_t p);
    return CODE_W - 1 - (int'(p) - int'(PH_SAR_FIRST));
  endfunction

  // One binary-search step: drop the tested bit on a low decision, set the next bit.
  function automatic code_t sar_step(code_t c, int b, logic keep);
    code_t r;
    r = c;
    if (!keep) r[b] = 1'b0;
    if (b > 0) r[b-1] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/tisar_phase_gen.sv
`timescale 1ns/1ps
module tisar_phase_gen import tisar_pkg::*; (
  input  logic                         clk,
  input  logic                         rst,
  output phase_t [FRAME_LEN-1:0]       phase
);
  always_ff @(posedge clk) begin
    for (int k = 0; k < FRAME_LEN; k++) begin
      if (rst) phase[k] <= reset_phase(k);
      else     phase[k] <= phase[k] + 1'b1;
    end
  end

  // Neighbouring slices stay exactly one step apart (R4).
  for (genvar k = 0; k < FRAME_LEN - 1; k++) begin : g_offs
    p_neighbour_offset_r4: assert property (@(posedge clk) disable iff (rst)
      phase[k+1] == phase_t'(phase[k] - 1'b1));
  end
endmodule

// File: rtl/tisar_slice_sar.sv
`timescale 1ns/1ps
module tisar_slice_sar import tisar_pkg::*; (
  input  logic   clk,
  input  logic   rst,
  input  phase_t phase,
  input  logic   cmp,
  output code_t  trial,
  output logic   armed
);
  logic searching;
  logic reload;
  int   bit_idx;

  assign searching = in_search(phase);
  assign reload    = (phase == PH_XFER);
  assign bit_idx   = trial_bit(phase);

  always_ff @(posedge clk) begin
    if (rst) begin
      trial <= MID_CODE;
      armed <= 1'b0;
    end else begin
      if (searching)   trial <= sar_step(trial, bit_idx, cmp);
      else if (reload) trial <= MID_CODE;
      if (phase == PH_SAMPLE) armed <= 1'b1;
    end
  end

  p_mid_at_start_r5: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SAR_FIRST) |-> (trial == MID_CODE));

  p_hold_settle_r8: assert property (@(posedge clk) disable iff (rst)
    (phase == phase_t'(PH_SAR_LAST + 1'b1)) |=> $stable(trial));
endmodule

// File: rtl/tisar_xfer_mux.sv
`timescale 1ns/1ps
module tisar_xfer_mux import tisar_pkg::*; (
  input  logic [FRAME_LEN-1:0]  xfer_stb,
  input  logic [FRAME_LEN-1:0]  armed,
  input  code_t [FRAME_LEN-1:0] trial,
  output logic                  valid,
  output code_t                 code,
  output phase_t                slice
);
  always_comb begin
    valid = 1'b0;
    code  = '0;
    slice = '0;
    for (int k = 0; k < FRAME_LEN; k++) begin
      if (xfer_stb[k]) begin
        valid = armed[k];
        slice = phase_t'(k);
        if (armed[k]) code = trial[k];
      end
    end
  end
endmodule

// File: rtl/tisar_sequencer.sv
`timescale 1ns/1ps
module tisar_sequencer import tisar_pkg::*; #(
  parameter int CAL_CYCLES = 10000
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [FRAME_LEN-1:0]        cmp_bit,
  output logic [FRAME_LEN-1:0]        zero_stb,
  output logic [FRAME_LEN-1:0]        azero_stb,
  output logic [FRAME_LEN-1:0]        acal_stb,
  output logic [FRAME_LEN-1:0]        samp_stb,
  output logic [FRAME_LEN-1:0]        xfer_stb,
  output logic [FRAME_LEN*CODE_W-1:0] trial_bus,
  output logic                        res_valid,
  output logic [CODE_W-1:0]           res_code,
  output logic [PH_W-1:0]             res_slice,
  output logic                        calibrated
);
  localparam int CNT_W = $clog2(CAL_CYCLES + 1);

  phase_t [FRAME_LEN-1:0] phase;
  code_t  [FRAME_LEN-1:0] trial;
  logic   [FRAME_LEN-1:0] armed;
  logic   [CNT_W-1:0]     cal_cnt;

  tisar_phase_gen u_phase (.clk(clk), .rst(rst), .phase(phase));

  for (genvar k = 0; k < FRAME_LEN; k++) begin : g_slice
    tisar_slice_sar u_sar (
      .clk(clk), .rst(rst), .phase(phase[k]), .cmp(cmp_bit[k]),
      .trial(trial[k]), .armed(armed[k])
    );
  end

  always_comb begin
    for (int k = 0; k < FRAME_LEN; k++) begin
      zero_stb[k]  = !rst && (phase[k] == PH_ZERO);
      azero_stb[k] = !rst && (phase[k] == PH_AZERO);
      acal_stb[k]  = !rst && (phase[k] == PH_ACAL);
      samp_stb[k]  = !rst && (phase[k] == PH_SAMPLE);
      xfer_stb[k]  = !rst && (phase[k] == PH_XFER);
    end
  end

  assign trial_bus = trial;

  tisar_xfer_mux u_xfer (
    .xfer_stb(xfer_stb), .armed(armed), .trial(trial),
    .valid(res_valid), .code(res_code), .slice(res_slice)
  );

  always_ff @(posedge clk) begin
    if (rst)                                  cal_cnt <= '0;
    else if (cal_cnt != CNT_W'(CAL_CYCLES))   cal_cnt <= cal_cnt + 1'b1;
  end
  assign calibrated = (cal_cnt == CNT_W'(CAL_CYCLES));

  p_single_sample_r3: assert property (@(posedge clk) disable iff (rst)
    $countones(samp_stb) == 1);

  p_valid_owner_r7: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> xfer_stb[res_slice]);

  p_cal_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    calibrated |=> calibrated);

  p_zero_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $countones(zero_stb) == 1);
endmodule

// File: tb/test_tisar_sequencer.sv
`timescale 1ns/1ps
module test_tisar_sequencer;
  localparam int NS   = 16;
  localparam int CW   = 9;
  localparam int CAL  = 10000;
  localparam int NCYC = CAL + 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NS-1:0] cmp_bit = '0;
  logic [NS-1:0] zero_stb, azero_stb, acal_stb, samp_stb, xfer_stb;
  logic [NS*CW-1:0] trial_bus;
  logic res_valid;
  logic [CW-1:0] res_code;
  logic [3:0] res_slice;
  logic calibrated;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;
  int held [NS];
  bit armed_b [NS];
  int q_slice [$];
  int q_code [$];
  int cap_idx = 0;

  always #4 clk = ~clk;

  tisar_sequencer #(.CAL_CYCLES(CAL)) i_tisar_sequencer (
    .clk(clk), .rst(rst), .cmp_bit(cmp_bit),
    .zero_stb(zero_stb), .azero_stb(azero_stb), .acal_stb(acal_stb),
    .samp_stb(samp_stb), .xfer_stb(xfer_stb), .trial_bus(trial_bus),
    .res_valid(res_valid), .res_code(res_code), .res_slice(res_slice),
    .calibrated(calibrated)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int trial_of(int k);
    return int'(trial_bus[k*CW +: CW]);
  endfunction

  function automatic int pick_value(int i);
    case (i)
      0: return 0;
      1: return 511;
      2: return 256;
      3: return 255;
      4: return 1;
      5: return 510;
      6: return 170;
      7: return 341;
      default: return int'($urandom_range(0, 511));
    endcase
  endfunction

  // Driver and monitor for one cycle n (n edges after reset release).
  task automatic run_cycle(int n);
    int s_samp, s_xfer, s_zero, s_start, s_hold;
    s_samp  = (n + 13) % NS;
    s_xfer  = (n + 1) % NS;
    s_zero  = n % NS;
    s_start = (n + 12) % NS;
    s_hold  = (n + 2) % NS;

    chk(zero_stb == NS'(1 << s_zero), "R2 zero strobe", int'(zero_stb), 1 << s_zero);
    chk($countones(samp_stb) == 1, "R3 one sampler", $countones(samp_stb), 1);
    chk(samp_stb == NS'(1 << s_samp), "R4 sample strobe", int'(samp_stb), 1 << s_samp);
    chk(azero_stb == NS'(1 << ((n + 15) % NS)), "R4 offset strobe", int'(azero_stb), 1 << ((n + 15) % NS));
    chk(acal_stb == NS'(1 << ((n + 14) % NS)), "R4 gain strobe", int'(acal_stb), 1 << ((n + 14) % NS));
    chk(xfer_stb == NS'(1 << s_xfer), "R4 transfer strobe", int'(xfer_stb), 1 << s_xfer);
    chk(trial_of(s_start) == 256, "R5 search start", trial_of(s_start), 256);
    chk(trial_of(s_zero) == 256, "R8 reload", trial_of(s_zero), 256);
    if (armed_b[s_hold])
      chk(trial_of(s_hold) == held[s_hold], "R8 settle hold", trial_of(s_hold), held[s_hold]);

    // Monitor: compare the handed-off word against the queue.
    chk(res_valid == armed_b[s_xfer], "R7 valid", int'(res_valid), int'(armed_b[s_xfer]));
    if (res_valid) begin
      if (q_slice.size() == 0) begin
        chk(1'b0, "R7 unexpected word", int'(res_code), -1);
      end else begin
        int es, ec;
        es = q_slice.pop_front();
        ec = q_code.pop_front();
        chk(int'(res_slice) == es, "R7 slice index", int'(res_slice), es);
        chk(int'(res_code) == ec, "R6 word", int'(res_code), ec);
      end
    end

    // Driver: the expected sampler takes a new value.
    held[s_samp] = pick_value(cap_idx);
    cap_idx++;
    armed_b[s_samp] = 1'b1;
    q_slice.push_back(s_samp);
    q_code.push_back(held[s_samp]);

    // Comparator model; random bits outside search steps (R10).
    for (int k = 0; k < NS; k++) begin
      int p;
      p = (n + NS - k) % NS;
      if (p >= 4 && p <= 12) cmp_bit[k] = (held[k] >= trial_of(k));
      else                   cmp_bit[k] = 1'($urandom_range(0, 1));
    end

    if (n == CAL - 1) chk(calibrated == 1'b0, "R9 not yet", int'(calibrated), 0);
    if (n == CAL)     chk(calibrated == 1'b1, "R9 reached", int'(calibrated), 1);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    for (int k = 0; k < NS; k++) begin
      held[k] = 0;
      armed_b[k] = 1'b0;
    end
    repeat (3) @(negedge clk);
    chk(samp_stb == '0 && zero_stb == '0 && xfer_stb == '0, "R1 strobes", int'(samp_stb), 0);
    chk(res_valid == 1'b0, "R1 valid", int'(res_valid), 0);
    chk(calibrated == 1'b0, "R1 calibrated", int'(calibrated), 0);
    for (int k = 0; k < NS; k++)
      chk(trial_of(k) == 256, "R1 trial", trial_of(k), 256);
    rst = 1'b0;
    for (int n = 0; n < NCYC; n++) begin
      #1;
      run_cycle(n);
      @(negedge clk);
    end
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule